// File: doc/BRIEF.md
# Edge Pulse Counter

This block counts transitions on one digital input. The transitions are taken only after a two-stage synchroniser and an optional glitch filter. Each edge polarity has its own action: count up, count down, or ignore. The filtered level of a second input, the control input, selects a modifier for that action. The modifier can keep the action, reverse its direction, or block it.

The result is a signed count. It returns to zero when it lands on a programmed high or low limit. The count is compared against two thresholds and against zero. Any of these five comparisons can set a sticky event flag. An interrupt line combines that flag with a mask bit.

Software sets the block up through a plain register port. The port has a write strobe, an address and write data, and returns combinational read data. Three configuration words, a control word, the count, the event flag and the mask are reached at addresses 0 to 6.

Top module: `edge_pulse_counter`

## Requirements
- R1: After reset, address 0 reads 0x00003C10, the count is 0, the event flag is 0 and the interrupt output is low.
- R2: Edge actions are set in address 0. The falling-edge code is at bits 17:16 and the rising-edge code at bits 19:18. Code 01 adds one, code 10 subtracts one, and codes 00 and 11 leave the count alone. With the filter off, an edge driven on the signal input shows on the count four clock edges later.
- R3: The control-input modifier is taken from bits 21:20 of address 0 while the control input is high, and from bits 23:22 while it is low. Code 00 keeps the edge action, 01 reverses up and down, and 10 blocks counting.
- R4: Bit 10 of address 0 enables the glitch filter. Bits 9:0 hold its threshold in clock cycles. With the filter on, a new input level is taken only once it has held for more than the threshold. Shorter pulses leave the count unchanged.
- R5: Address 3 is the control word. While bit 0 is set the count is held at 0. While bit 1 is set, and bit 0 is clear, the count does not change.
- R6: Address 2 holds the high limit in bits 15:0 and the low limit in bits 31:16. A step that lands on either limit loads 0 in the same cycle. The matching event is raised only if its enable is set: bit 12 of address 0 for the high limit, bit 13 for the low limit.
- R7: Address 1 holds threshold 0 in bits 15:0 and threshold 1 in bits 31:16. A threshold event fires only on the step that makes the count equal to that threshold. Threshold 0 is enabled by bit 14 of address 0 and threshold 1 by bit 15.
- R8: A step that makes the count zero raises the zero event when bit 11 of address 0 is set.
- R9: Any enabled event sets the flag, read at bit 0 of address 5. The flag stays set until a 1 is written to bit 0 of address 5. The interrupt output is the flag ANDed with bit 0 of address 6.
- R10: Addresses 1 to 3 read back what was written. Address 4 returns the count, sign-extended to 32 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sig_in | input | 1 | Input whose edges are counted |
| ctl_in | input | 1 | Control input whose level selects the modifier |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| count | output | 16 | Current signed count |
| evt_raw | output | 1 | Sticky event flag |
| irq | output | 1 | Masked interrupt |

## Verification
Each error inside the block shows at the count port within a few cycles of the edge that exposes it:
- A mis-decoded action code or modifier makes the count move the wrong way, or not at all, four cycles after an unfiltered edge.
- A filter counter that is off by one accepts a pulse of exactly the threshold length, or rejects one a cycle longer.
- A wrong limit or threshold compare shows as a missing wrap to zero, or as a wrong event flag, on the same step.
- A lost or spurious flag appears at the interrupt pin in the next cycle.

// File: rtl/edge_pulse_counter.sv
module edge_pulse_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sig_in,
  input  logic             ctl_in,
  input  logic             reg_we,
  input  logic [2:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  output logic [CNT_W-1:0] count,
  output logic             evt_raw,
  output logic             irq
);
  localparam int FLT_W = 10;
  localparam logic [31:0] CFG0_INIT = 32'h0000_3C10;

  logic [31:0] cfg0, cfg1, cfg2;
  logic        hold_zero, hold_pause, mask_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg0 <= CFG0_INIT;
      cfg1 <= '0;
      cfg2 <= '0;
      hold_zero <= 1'b0;
      hold_pause <= 1'b0;
      mask_en <= 1'b0;
    end else if (reg_we) begin
      case (reg_addr)
        3'd0: cfg0 <= reg_wdata;
        3'd1: cfg1 <= reg_wdata;
        3'd2: cfg2 <= reg_wdata;
        3'd3: {hold_pause, hold_zero} <= reg_wdata[1:0];
        3'd6: mask_en <= reg_wdata[0];
        default: ;
      endcase
    end
  end

  wire [FLT_W-1:0] flt_thr = cfg0[FLT_W-1:0];
  wire             flt_on  = cfg0[10];

  // bit 0: signal, bit 1: control
  logic [1:0] sy1, sy2, lvl, lvl_d;
  logic [FLT_W-1:0] stab [2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sy1 <= '0;
      sy2 <= '0;
      lvl <= '0;
      lvl_d <= '0;
      stab[0] <= '0;
      stab[1] <= '0;
    end else begin
      sy1 <= {ctl_in, sig_in};
      sy2 <= sy1;
      lvl_d <= lvl;
      for (int i = 0; i < 2; i++) begin
        if (!flt_on) begin
          lvl[i] <= sy2[i];
          stab[i] <= '0;
        end else if (sy2[i] == lvl[i]) begin
          stab[i] <= '0;
        end else if (stab[i] >= flt_thr) begin
          lvl[i] <= sy2[i];
          stab[i] <= '0;
        end else begin
          stab[i] <= stab[i] + 1'b1;
        end
      end
    end
  end

  wire rise = lvl[0] & ~lvl_d[0];
  wire fall = ~lvl[0] & lvl_d[0];
  wire [1:0] act  = rise ? cfg0[19:18] : (fall ? cfg0[17:16] : 2'b00);
  wire [1:0] modc = lvl[1] ? cfg0[21:20] : cfg0[23:22];
  wire swap  = (modc == 2'b01);
  wire block = (modc == 2'b10);
  wire up    = !block && ((act == 2'b01 && !swap) || (act == 2'b10 && swap));
  wire down  = !block && ((act == 2'b10 && !swap) || (act == 2'b01 && swap));
  wire step  = (up || down) && !hold_zero && !hold_pause;

  logic signed [CNT_W-1:0] cnt;
  wire signed [CNT_W-1:0] nxt  = up ? cnt + 1'b1 : cnt - 1'b1;
  wire signed [CNT_W-1:0] hlim = cfg2[CNT_W-1:0];
  wire signed [CNT_W-1:0] llim = cfg2[16 +: CNT_W];
  wire signed [CNT_W-1:0] thr0 = cfg1[CNT_W-1:0];
  wire signed [CNT_W-1:0] thr1 = cfg1[16 +: CNT_W];

  wire hit_h = step && (nxt == hlim);
  wire hit_l = step && (nxt == llim);
  wire [4:0] ev = {step && (nxt == thr1), step && (nxt == thr0), hit_l, hit_h,
                   step && (nxt == '0)} & cfg0[15:11];
  wire clr_raw = reg_we && (reg_addr == 3'd5) && reg_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      evt_raw <= 1'b0;
    end else begin
      if (hold_zero) cnt <= '0;
      else if (step) cnt <= (hit_h || hit_l) ? '0 : nxt;
      if (|ev) evt_raw <= 1'b1;
      else if (clr_raw) evt_raw <= 1'b0;
    end
  end

  assign count = cnt;
  assign irq   = evt_raw & mask_en;

  always_comb begin
    case (reg_addr)
      3'd0: reg_rdata = cfg0;
      3'd1: reg_rdata = cfg1;
      3'd2: reg_rdata = cfg2;
      3'd3: reg_rdata = {30'b0, hold_pause, hold_zero};
      3'd4: reg_rdata = 32'(cnt);
      3'd5: reg_rdata = {31'b0, evt_raw};
      3'd6: reg_rdata = {31'b0, mask_en};
      default: reg_rdata = '0;
    endcase
  end

  AST_RST_HOLDS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    hold_zero |=> cnt == '0); // R5
  AST_PAUSE_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_zero && hold_pause) |=> cnt == $past(cnt)); // R5
  AST_UNIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_zero |=> (CNT_W'(cnt - $past(cnt)) inside {'0, CNT_W'(1), '1}) || cnt == '0); // R2
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_raw && !clr_raw) |=> evt_raw); // R9
endmodule

// File: tb/edge_pulse_counter_test.sv
module edge_pulse_counter_test;
  localparam int CLK_PER = 10;

  logic clk = 0, rst_n = 0, sig_in = 0, ctl_in = 0, reg_we = 0;
  logic [2:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic [15:0] count;
  logic evt_raw, irq;
  int ntests = 0, nfail = 0;
  bit done = 0;

  always #(CLK_PER/2) clk = ~clk;

  edge_pulse_counter uut (.clk, .rst_n, .sig_in, .ctl_in, .reg_we, .reg_addr,
    .reg_wdata, .reg_rdata, .count, .evt_raw, .irq);

  typedef struct { int kind; logic [31:0] exp; string tag; } item_t;
  item_t sbq[$];
  event chk_ev;

  initial forever begin
    @(chk_ev);
    while (sbq.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = sbq.pop_front();
      case (it.kind)
        0: act = {16'b0, count};
        1: act = {31'b0, evt_raw};
        2: act = {31'b0, irq};
        default: act = reg_rdata;
      endcase
      ntests++;
      if (act !== it.exp) begin
        nfail++;
        $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
      end
    end
  end

  task automatic expect_val(int kind, logic [31:0] exp, string tag);
    item_t it;
    it.kind = kind; it.exp = exp; it.tag = tag;
    sbq.push_back(it);
    ->chk_ev;
    #1;
  endtask

  task automatic expect_rd(logic [2:0] a, logic [31:0] exp, string tag);
    reg_addr = a;
    #1;
    expect_val(3, exp, tag);
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic set_sig(logic v);
    @(negedge clk);
    sig_in = v;
    repeat (16) @(negedge clk);
  endtask

  task automatic pulse(int w);
    @(negedge clk);
    sig_in = 1;
    repeat (w) @(negedge clk);
    sig_in = 0;
    repeat (16) @(negedge clk);
  endtask

  function automatic logic [31:0] mk0(logic [9:0] thr, logic fen, logic [4:0] evs,
      logic [1:0] neg, logic [1:0] pos, logic [1:0] hc, logic [1:0] lc);
    return {8'h0, lc, hc, pos, neg, evs, fen, thr};
  endfunction

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", ntests, nfail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    expect_rd(0, 32'h0000_3C10, "R1 cfg0 reset");
    expect_val(0, 0, "R1 count reset");
    expect_val(1, 0, "R1 flag reset");
    expect_val(2, 0, "R1 irq reset");

    wr(2, {16'hFF9C, 16'd100});
    wr(0, mk0(0, 0, 0, 2'b00, 2'b01, 2'b00, 2'b00));
    // R2 latency: counted on the fourth edge
    @(negedge clk); sig_in = 1;
    repeat (3) @(negedge clk);
    expect_val(0, 0, "R2 before latency");
    @(negedge clk);
    expect_val(0, 1, "R2 after four edges");
    set_sig(0);
    expect_val(0, 1, "R2 falling code 00 ignored");
    pulse(3); pulse(3);
    expect_val(0, 3, "R2 rising increments");

    wr(0, mk0(0, 0, 0, 2'b10, 2'b01, 2'b00, 2'b00));
    set_sig(1);
    expect_val(0, 4, "R2 rise up");
    set_sig(0);
    expect_val(0, 3, "R2 fall down");
    wr(0, mk0(0, 0, 0, 2'b10, 2'b11, 2'b00, 2'b00));
    pulse(4);
    expect_val(0, 2, "R2 code 11 ignored");

    ctl_in = 1;
    wr(0, mk0(0, 0, 0, 2'b00, 2'b01, 2'b01, 2'b00));
    pulse(4);
    expect_val(0, 1, "R3 high swap");
    wr(0, mk0(0, 0, 0, 2'b00, 2'b01, 2'b10, 2'b00));
    pulse(4);
    expect_val(0, 1, "R3 high block");
    ctl_in = 0;
    wr(0, mk0(0, 0, 0, 2'b00, 2'b10, 2'b10, 2'b01));
    pulse(4);
    expect_val(0, 2, "R3 low swap of down");

    wr(0, mk0(5, 1, 0, 2'b00, 2'b01, 2'b00, 2'b00));
    pulse(5);
    expect_val(0, 2, "R4 short pulse rejected");
    pulse(6);
    expect_val(0, 3, "R4 long pulse accepted");

    wr(3, 2);
    pulse(10);
    expect_val(0, 3, "R5 pause freezes");
    expect_rd(3, 2, "R10 ctrl readback");
    wr(3, 0);
    pulse(10);
    expect_val(0, 4, "R5 counting resumes");
    wr(3, 1);
    pulse(10);
    expect_val(0, 0, "R5 reset holds zero");
    wr(3, 0);

    wr(2, {16'hFFFE, 16'd3});
    wr(0, mk0(0, 0, 5'b00010, 2'b00, 2'b01, 2'b00, 2'b00));
    wr(6, 1);
    wr(5, 1);
    pulse(4); pulse(4);
    expect_val(0, 2, "R6 below high limit");
    expect_val(1, 0, "R6 no event yet");
    pulse(4);
    expect_val(0, 0, "R6 wrap at high limit");
    expect_val(1, 1, "R6 high limit event");
    expect_val(2, 1, "R9 irq with mask");
    wr(5, 1);
    expect_val(1, 0, "R9 flag cleared");
    expect_val(2, 0, "R9 irq cleared");
    wr(0, mk0(0, 0, 5'b00000, 2'b00, 2'b10, 2'b00, 2'b00));
    pulse(4);
    expect_val(0, 16'hFFFF, "R6 down to -1");
    pulse(4);
    expect_val(0, 0, "R6 wrap at low limit");
    expect_val(1, 0, "R6 disabled event silent");

    wr(1, {16'd5, 16'd2});
    wr(2, {16'hFFF6, 16'd10});
    wr(0, mk0(0, 0, 5'b01000, 2'b00, 2'b01, 2'b00, 2'b00));
    pulse(4);
    expect_val(1, 0, "R7 below threshold 0");
    pulse(4);
    expect_val(1, 1, "R7 threshold 0 event");
    wr(5, 1);
    pulse(4);
    expect_val(1, 0, "R7 no event past threshold");
    wr(0, mk0(0, 0, 5'b10000, 2'b00, 2'b01, 2'b00, 2'b00));
    pulse(4);
    expect_val(1, 0, "R7 below threshold 1");
    pulse(4);
    expect_val(1, 1, "R7 threshold 1 event");
    expect_val(0, 5, "R7 count value");
    expect_rd(1, 32'h0005_0002, "R10 cfg1 readback");
    expect_rd(2, 32'hFFF6_000A, "R10 cfg2 readback");

    wr(5, 1);
    wr(0, mk0(0, 0, 5'b00001, 2'b00, 2'b10, 2'b00, 2'b00));
    for (int i = 0; i < 4; i++) pulse(4);
    expect_val(1, 0, "R8 not yet zero");
    pulse(4);
    expect_val(0, 0, "R8 count zero");
    expect_val(1, 1, "R8 zero event");
    wr(6, 0);
    expect_val(2, 0, "R9 irq masked");
    wr(6, 1);
    expect_val(2, 1, "R9 irq unmasked");
    pulse(4);
    expect_rd(4, 32'hFFFF_FFFF, "R10 count sign-extended");

    done = 1;
    #1;
    $display("[TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end
endmodule